// File: doc/BRIEF.md
# Indexed Entry Table Access Port

This block gives software a window into an internal table of 68-bit address entries. The table cannot be reached directly from the bus. Software moves an entry through three 32-bit staging words instead. To fetch an entry, software writes its index to a table-command register with the command bit clear. The entry is then copied into the staging words, and software reads it from there. To store an entry, software first fills the three staging words and then writes the index with the command bit set.

The staging words hold the entry in reverse order. The first word carries the top four entry bits, the second carries bits 63..32 and the third carries bits 31..0. A read-only identification register reports a major and a minor revision. The table depth is a parameter. The storage is a synchronous-read memory, so it maps onto block RAM. The bus is a simple 32-bit register port: a write strobe, a read strobe, a byte address and a registered read-data output.

Top module: `tbl_access_port`

## Requirements
- R1: The register at offset 0x00 reads as major revision in bits 15:8, minor revision in bits 7:0 and zero in bits 31:16. A bus write to it has no effect.
- R2: A read strobe at any offset puts the selected value on bus_rdata on the next clock edge. While no read strobe is given, bus_rdata holds its value.
- R3: The staging words sit at offsets 0x34 (word 0), 0x38 (word 1) and 0x3C (word 2). Word 0 stores only bits 3:0 of what is written, and its bits 31:4 always read as zero.
- R4: Writing offset 0x20 with bit 31 set stores an entry at the index given in bits 30:0. Entry bits 67:64 come from word 0 bits 3:0, bits 63:32 from word 1, and bits 31:0 from word 2.
- R5: Writing offset 0x20 with bit 31 clear copies the entry at the given index into the staging words, using the R4 bit mapping. The copied values are returned by a read strobe issued in the very next cycle.
- R6: A store command whose index is at or beyond the table depth changes no entry. A fetch command with such an index sets all three staging words to zero.
- R7: Reading offset 0x20 returns the index of the most recent command in bits 30:0, with bit 31 read as zero.
- R8: Any offset other than 0x00, 0x20, 0x34, 0x38 and 0x3C reads as zero, and a write to it changes no state.
- R9: After reset, bus_rdata, the command index and all three staging words are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data, valid one cycle after bus_rd |

## Verification
A fault in the bit mapping or in the memory addressing shows up as a wrong word on the very first fetch of the affected entry. That read comes one cycle after the fetch command. The bench fills every entry with a distinct pattern and fetches each one back, so a swapped word, a lost upper nibble or an aliased index cannot go unseen. A fault in the pending-fetch path shows up only on back-to-back command and read. For that reason every fetch in the sweep is followed at once by its first read. Range faults on the index would corrupt a valid entry. A full re-read after the out-of-range store would expose that.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int WORD_W  = 32;
  localparam int ENTRY_W = 68;
  localparam int TOP_W   = ENTRY_W - 2 * WORD_W;
  localparam int NWORDS  = 3;
  localparam int CMD_BIT = 31;

  localparam logic [7:0] OFS_ID   = 8'h00;
  localparam logic [7:0] OFS_CMD  = 8'h20;
  localparam logic [7:0] OFS_WORD = 8'h34;

  typedef struct packed {
    logic [TOP_W-1:0]  hi;
    logic [WORD_W-1:0] mid;
    logic [WORD_W-1:0] lo;
  } entry_t;

  typedef logic [NWORDS-1:0][WORD_W-1:0] words_t;

  function automatic words_t to_words(entry_t e);
    words_t w;
    w[0] = {{(WORD_W-TOP_W){1'b0}}, e.hi};
    w[1] = e.mid;
    w[2] = e.lo;
    return w;
  endfunction

  function automatic entry_t from_words(words_t w);
    entry_t e;
    e.hi  = w[0][TOP_W-1:0];
    e.mid = w[1];
    e.lo  = w[2];
    return e;
  endfunction
endpackage

// File: rtl/tap_decode.sv
module tap_decode #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              sel_id,
  output logic              sel_cmd,
  output logic [2:0]        sel_word
);
  import tap_pkg::*;

  assign sel_id  = (addr == ADDR_W'(OFS_ID));
  assign sel_cmd = (addr == ADDR_W'(OFS_CMD));

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    assign sel_word[k] = (addr == ADDR_W'(OFS_WORD + 8'(4 * k)));
  end
endmodule

// File: rtl/tap_ram.sv
module tap_ram #(
  parameter int DEPTH = 16,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic                  clk,
  input  logic                  we,
  input  logic [IDX_W-1:0]      waddr,
  input  tap_pkg::entry_t       wdata,
  input  logic                  re,
  input  logic [IDX_W-1:0]      raddr,
  output tap_pkg::entry_t       rdata
);
  import tap_pkg::*;

  entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/tap_stage.sv
module tap_stage (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr,
  input  logic [2:0]            sel_word,
  input  logic [31:0]           wdata,
  input  logic                  fetch_go,
  input  logic                  fetch_oor,
  input  tap_pkg::entry_t       ram_q,
  output tap_pkg::words_t       view
);
  import tap_pkg::*;

  localparam logic [WORD_W-1:0] W0_MASK = WORD_W'((1 << TOP_W) - 1);

  words_t stg;
  logic   pend;
  logic   pend_oor;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= 1'b0;
      pend_oor <= 1'b0;
    end else begin
      pend     <= fetch_go;
      pend_oor <= fetch_oor;
    end
  end

  always_comb begin
    if (!pend)         view = stg;
    else if (pend_oor) view = '0;
    else               view = to_words(ram_q);
  end

  for (genvar k = 0; k < NWORDS; k++) begin : g_stg
    localparam logic [WORD_W-1:0] KEEP = (k == 0) ? W0_MASK : '1;
    always_ff @(posedge clk) begin
      if (rst)                     stg[k] <= '0;
      else if (wr && sel_word[k])  stg[k] <= wdata & KEEP;
      else                         stg[k] <= view[k];
    end
  end
endmodule

// File: rtl/tbl_access_port.sv
module tbl_access_port #(
  parameter int          DEPTH     = 16,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  REV_MAJOR = 8'h01,
  parameter logic [7:0]  REV_MINOR = 8'h03
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  import tap_pkg::*;

  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic       sel_id, sel_cmd;
  logic [2:0] sel_word;
  logic [30:0] cmd_idx;
  logic       idx_ok, cmd_wr, do_store, do_fetch;
  entry_t     ram_q;
  words_t     view;

  tap_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr     (bus_addr),
    .sel_id   (sel_id),
    .sel_cmd  (sel_cmd),
    .sel_word (sel_word)
  );

  assign idx_ok   = ({1'b0, bus_wdata[30:0]} < 32'(DEPTH));
  assign cmd_wr   = bus_wr && sel_cmd;
  assign do_store = cmd_wr && bus_wdata[CMD_BIT] && idx_ok;
  assign do_fetch = cmd_wr && !bus_wdata[CMD_BIT];

  tap_ram #(.DEPTH(DEPTH)) u_ram (
    .clk   (clk),
    .we    (do_store),
    .waddr (bus_wdata[IDX_W-1:0]),
    .wdata (from_words(view)),
    .re    (do_fetch && idx_ok),
    .raddr (bus_wdata[IDX_W-1:0]),
    .rdata (ram_q)
  );

  tap_stage u_stage (
    .clk       (clk),
    .rst       (rst),
    .wr        (bus_wr),
    .sel_word  (sel_word),
    .wdata     (bus_wdata),
    .fetch_go  (do_fetch),
    .fetch_oor (do_fetch && !idx_ok),
    .ram_q     (ram_q),
    .view      (view)
  );

  always_ff @(posedge clk) begin
    if (rst)         cmd_idx <= '0;
    else if (cmd_wr) cmd_idx <= bus_wdata[30:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (sel_id)           bus_rdata <= {16'h0, REV_MAJOR, REV_MINOR};
      else if (sel_cmd)     bus_rdata <= {1'b0, cmd_idx};
      else if (sel_word[0]) bus_rdata <= view[0];
      else if (sel_word[1]) bus_rdata <= view[1];
      else if (sel_word[2]) bus_rdata <= view[2];
      else                  bus_rdata <= '0;
    end
  end
endmodule

// File: rtl/tap_checker.sv
module tap_checker #(
  parameter int          DEPTH     = 16,
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  REV_MAJOR = 8'h01,
  parameter logic [7:0]  REV_MINOR = 8'h03
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata
);
  // R1
  a_r1_id_value: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(8'h00)) |=> (bus_rdata == {16'h0, REV_MAJOR, REV_MINOR}));

  // R2
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

  // R3
  a_r3_word0_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(8'h34)) |=> (bus_rdata[31:4] == '0));

  // R6
  a_r6_oor_fetch_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_rd && bus_addr == ADDR_W'(8'h20) && !bus_wdata[31]
      && ({1'b0, bus_wdata[30:0]} >= 32'(DEPTH)))
    ##1 (bus_rd && !bus_wr && bus_addr == ADDR_W'(8'h38)) |=> (bus_rdata == '0));

  // R7
  a_r7_cmd_bit_clear: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(8'h20)) |=> !bus_rdata[31]);

  // R8
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == ADDR_W'(8'h44)) |=> (bus_rdata == '0));
endmodule

bind tbl_access_port tap_checker #(
  .DEPTH(DEPTH), .ADDR_W(ADDR_W), .REV_MAJOR(REV_MAJOR), .REV_MINOR(REV_MINOR)
) u_tap_checker (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/tbl_access_port_bench.sv
module tbl_access_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;
  localparam int ADDR_W = 8;
  localparam logic [7:0] MAJ = 8'h01;
  localparam logic [7:0] MIN = 8'h03;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tbl_access_port #(.DEPTH(DEPTH), .ADDR_W(ADDR_W), .REV_MAJOR(MAJ), .REV_MINOR(MIN))
    u_tbl_access_port (
      .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  function automatic logic [31:0] pat0(int i);
    return 32'((i * 3 + 5) & 15);
  endfunction
  function automatic logic [31:0] pat1(int i);
    return 32'h9E37_79B9 * 32'(i + 1);
  endfunction
  function automatic logic [31:0] pat2(int i);
    return ~pat1(i) ^ 32'(i << 4);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Both tasks start and end at a falling edge.
  task automatic bwr(logic [7:0] a, logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic brd(logic [7:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9 reset state
    check("R9 rdata", bus_rdata, 32'h0);
    brd(8'h38, v); check("R9 word1", v, 32'h0);
    brd(8'h20, v); check("R9 cmd", v, 32'h0);

    // R1 identification, write ignored
    brd(8'h00, v); check("R1 id", v, {16'h0, MAJ, MIN});
    bwr(8'h00, 32'hFFFF_FFFF);
    brd(8'h00, v); check("R1 id after write", v, {16'h0, MAJ, MIN});

    // R2 hold without strobe
    repeat (3) @(negedge clk);
    check("R2 hold", bus_rdata, {16'h0, MAJ, MIN});

    // R3/R4 fill every entry; word0 upper bits written as ones
    for (int i = 0; i < DEPTH; i++) begin
      bwr(8'h34, 32'hFFFF_FFF0 | pat0(i));
      bwr(8'h38, pat1(i));
      bwr(8'h3C, pat2(i));
      if (i == 0) begin
        brd(8'h34, v); check("R3 word0 mask", v, pat0(0));
      end
      bwr(8'h20, 32'h8000_0000 | 32'(i));
    end

    // R6 out-of-range store must not alias any entry
    bwr(8'h34, 32'h0000_000F);
    bwr(8'h38, 32'hDEAD_BEEF);
    bwr(8'h3C, 32'hCAFE_F00D);
    bwr(8'h20, 32'h8000_0000 | 32'(DEPTH));
    bwr(8'h20, 32'h8000_0000 | 32'(DEPTH + 1));

    // R5/R4 fetch each entry, first read in the very next cycle
    for (int i = DEPTH - 1; i >= 0; i--) begin
      bwr(8'h20, 32'(i));
      brd(8'h38, v); check("R5 word1", v, pat1(i));
      brd(8'h34, v); check("R4 word0", v, pat0(i));
      brd(8'h3C, v); check("R4 word2", v, pat2(i));
    end

    // R7 command readback
    bwr(8'h20, 32'h8000_0000 | 32'd5);
    brd(8'h20, v); check("R7 cmd idx", v, 32'd5);

    // R6 out-of-range fetch zeroes staging
    bwr(8'h20, 32'(DEPTH + 4));
    brd(8'h38, v); check("R6 oor word1", v, 32'h0);
    brd(8'h34, v); check("R6 oor word0", v, 32'h0);
    brd(8'h3C, v); check("R6 oor word2", v, 32'h0);

    // R8 unmapped offset
    bwr(8'h20, 32'd3);
    bwr(8'h44, 32'h1234_5678);
    brd(8'h44, v); check("R8 unmapped", v, 32'h0);
    brd(8'h38, v); check("R8 word1 kept", v, pat1(3));
    brd(8'h20, v); check("R8 cmd kept", v, 32'd3);

    // R3 staging word write and readback
    bwr(8'h3C, 32'h0BAD_CAFE);
    brd(8'h3C, v); check("R3 word2 rw", v, 32'h0BAD_CAFE);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule